// File: doc/BRIEF.md
# Programmable Delayed Frame Sync Generator

This block turns a free-running serial data clock into a periodic frame sync. The frame length is set in data-clock periods. A typical setting is the clock rate divided by 8000, which gives the usual 8 kHz voice frame. Inside each frame, one pulse is placed at a programmable distance from the frame start. Its width is one of four fixed lengths.

The block runs on the same clock as the serial ports it serves. It also emits a one-cycle frame marker. The main sync and this marker are the timing reference for further copies of the block, which produce delayed syncs for secondary ports from the same clock.

Offset, width and frame length are sampled only at a frame boundary, so a change never produces a runt pulse. A pulse that would run past the end of its frame is cut off there and never spills into the next frame.

Top module: `fsync_gen`

## Requirements
- R1: `frame_tick` is high for exactly one cycle per frame, in the first cycle of each frame. Frames are N clocks long, where N is the frame length in force for that frame. A `frame_len` value of 0 or 1 is treated as 2.
- R2: `width_sel` sets the pulse width as follows: 2'b00 gives 1 clock, 2'b01 gives 2 clocks, 2'b10 gives 8 clocks and 2'b11 gives 16 clocks.
- R3: The first cycle of the pulse is the cycle at position `offset` within the frame. Position 0 is the `frame_tick` cycle.
- R4: `offset` covers the full 10-bit range, 0 to 1023, in single-clock steps. If `offset` is not below the frame length, no pulse appears in that frame.
- R5: From reset until the first frame count completes, both `fsync` and `frame_tick` stay low. The first frame ends when the count reaches the value on `frame_len` at that time.
- R6: `frame_len`, `width_sel` and `offset` are sampled only at the clock edge that starts a new frame. The sampled values govern that whole frame. Changes at any other time have no effect on the outputs until the next frame starts.
- R7: If the offset plus the width goes past the frame length, the pulse ends with the last cycle of the frame. It does not continue into the following frame.
- R8: When the pulse fits inside the frame, `fsync` stays high for exactly the selected number of consecutive cycles and is low in every other cycle of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_len | input | CNT_W (11) | Frame length in data clocks, sampled at each frame start |
| width_sel | input | 2 | Pulse width code, sampled at each frame start |
| offset | input | OFS_W (10) | Pulse position within the frame in clocks, sampled at each frame start |
| fsync | output | 1 | Frame sync pulse |
| frame_tick | output | 1 | One-cycle marker for the first cycle of each frame |

## Verification
Two events can land on the same edge: the frame wrap that samples new settings, and a fresh write of those settings. The bench provokes this on purpose. It waits for the last cycle of a frame, then drives a new offset, width and length in that very cycle, and expects the new values to shape the frame that starts at the next edge.

A second collision is a pulse truncated at the end of one frame meeting an offset-zero pulse at the start of the next. It is judged cycle by cycle: the bench checks that `fsync` lengths come from each frame's own settings and that no spill-over occurs.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

   // Pulse width codes as driven on the width_sel pins.
   typedef enum logic [1:0] {
      FS_W1  = 2'b00,
      FS_W2  = 2'b01,
      FS_W8  = 2'b10,
      FS_W16 = 2'b11
   } fs_width_e;

   // Bits needed to hold the widest pulse (16) plus headroom for a run counter.
   localparam int FS_RUN_W = 5;

   function automatic logic [FS_RUN_W-1:0] fs_width_clks(input fs_width_e sel);
      logic [FS_RUN_W-1:0] n;
      case (sel)
         FS_W1:   n = FS_RUN_W'(1);
         FS_W2:   n = FS_RUN_W'(2);
         FS_W8:   n = FS_RUN_W'(8);
         default: n = FS_RUN_W'(16);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/fsync_cfg_shadow.sv
module fsync_cfg_shadow
   import fsync_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int OFS_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [CNT_W-1:0]    len_in,
   input  logic [OFS_W-1:0]    off_in,
   input  fs_width_e           wsel_in,
   output logic [CNT_W-1:0]    len_q,
   output logic [OFS_W-1:0]    off_q,
   output logic [FS_RUN_W-1:0] wclk_q
);

   // Settings are captured only on a frame wrap (R6).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= CNT_W'(2);
         off_q  <= '0;
         wclk_q <= FS_RUN_W'(1);
      end else if (load) begin
         len_q  <= len_in;
         off_q  <= off_in;
         wclk_q <= fs_width_clks(wsel_in);
      end
   end

   // R6: shadowed settings never move between frame wraps
   a_r6_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(len_q) && $stable(off_q) && $stable(wclk_q)));

endmodule

// File: rtl/fsync_frame_ctr.sv
module fsync_frame_ctr #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] len_live,
   input  logic [CNT_W-1:0] len_act,
   output logic [CNT_W-1:0] cnt,
   output logic             primed,
   output logic             wrap
);

   logic [CNT_W-1:0] term;

   // The first frame after reset uses the live length; later frames use the shadow.
   always_comb begin
      term = primed ? len_act : len_live;
      wrap = (cnt == term - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         primed <= 1'b0;
      end else begin
         cnt    <= wrap ? '0 : cnt + 1'b1;
         primed <= primed | wrap;
      end
   end

   // R1: position never reaches the active frame length
   a_r1_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (cnt < len_act));

   // R5: priming happens only on completion of a frame count
   a_r5_prime_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(primed) |-> (cnt == '0));

endmodule

// File: rtl/fsync_window.sv
module fsync_window
   import fsync_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int OFS_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    cnt,
   input  logic                primed,
   input  logic [OFS_W-1:0]    off,
   input  logic [FS_RUN_W-1:0] wclk,
   output logic                pulse,
   output logic                tick
);

   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] lo, hi, pos;

   // The window is bounded by the counter range, so truncation at frame end is inherent (R7).
   always_comb begin
      pos   = EXT_W'(cnt);
      lo    = EXT_W'(off);
      hi    = lo + EXT_W'(wclk);
      pulse = primed && (pos >= lo) && (pos < hi);
      tick  = primed && (cnt == '0);
   end

   // High cycles of fsync seen so far in the current frame (assertion support).
   logic [FS_RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (tick)  run_q <= pulse ? FS_RUN_W'(1) : '0;
      else if (pulse) run_q <= run_q + 1'b1;
   end

   // R2/R8: never more high cycles in one frame than the selected width
   a_r2_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !tick && primed && $past(primed)) |-> (run_q < wclk));

   // R3: a rising pulse starts at the programmed offset
   a_r3_rise_at_offset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> (EXT_W'(cnt) == EXT_W'(off)));

   // R7: a nonzero offset never shows a pulse in the first frame cycle
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (off != '0)) |-> !pulse);

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
   import fsync_pkg::*;
#(
   parameter int CNT_W   = 11,
   parameter int OFS_W   = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] frame_len,
   input  logic [1:0]       width_sel,
   input  logic [OFS_W-1:0] offset,
   output logic             fsync,
   output logic             frame_tick
);

   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

   // Elaboration-time parameter checks
   if (CNT_W < 5)      begin : g_bad_cnt $error("fsync_gen: CNT_W must be at least 5"); end
   if (OFS_W < 1)      begin : g_bad_ofs $error("fsync_gen: OFS_W must be at least 1"); end
   if (OFS_W >= CNT_W) begin : g_bad_rel $error("fsync_gen: OFS_W must be below CNT_W"); end

   logic [CNT_W-1:0]    len_cl;
   logic [CNT_W-1:0]    len_act;
   logic [OFS_W-1:0]    off_act;
   logic [FS_RUN_W-1:0] w_act;
   logic [CNT_W-1:0]    cnt;
   logic                primed, wrap;
   logic                pulse_raw, tick_raw;

   assign len_cl = (frame_len < MIN_LEN) ? MIN_LEN : frame_len;

   fsync_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .len_live (len_cl),
      .len_act  (len_act),
      .cnt      (cnt),
      .primed   (primed),
      .wrap     (wrap)
   );

   fsync_cfg_shadow #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wrap),
      .len_in  (len_cl),
      .off_in  (offset),
      .wsel_in (fs_width_e'(width_sel)),
      .len_q   (len_act),
      .off_q   (off_act),
      .wclk_q  (w_act)
   );

   fsync_window #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .primed (primed),
      .off    (off_act),
      .wclk   (w_act),
      .pulse  (pulse_raw),
      .tick   (tick_raw)
   );

   // Output variant: straight from registered state, or retimed by one clock.
   if (OUT_REG) begin : g_out_reg
      logic fs_q, tk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fs_q <= 1'b0;
            tk_q <= 1'b0;
         end else begin
            fs_q <= pulse_raw;
            tk_q <= tick_raw;
         end
      end
      assign fsync      = fs_q;
      assign frame_tick = tk_q;
   end else begin : g_out_comb
      assign fsync      = pulse_raw;
      assign frame_tick = tick_raw;
   end

   // R5: quiet until the first frame count has completed
   a_r5_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> (!pulse_raw && !tick_raw));

   // R1: frame marker follows a wrap on the previous edge
   a_r1_tick_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(primed) && $past(wrap)) |-> tick_raw);

   // R4: an offset at or beyond the frame length gives no pulse
   a_r4_offset_beyond: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (CNT_W'(off_act) >= len_act)) |-> !pulse_raw);

endmodule

// File: tb/fsync_gen_bench.sv
module fsync_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] frame_len = 11'd20;
   logic [1:0]  width_sel = 2'b00;
   logic [9:0]  offset = 10'd0;
   logic        fsync, frame_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   fsync_gen u_fsync_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_len  (frame_len),
      .width_sel  (width_sel),
      .offset     (offset),
      .fsync      (fsync),
      .frame_tick (frame_tick)
   );

   // ---------------- reference model built from the requirements ----------------
   function automatic int clampl(input int l);
      return (l < 2) ? 2 : l;
   endfunction

   function automatic int wdec(input logic [1:0] c); // R2 encoding
      case (c)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 8;
         default: return 16;
      endcase
   endfunction

   int m_cnt, m_len, m_off, m_w, m_term;
   bit m_primed;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_primed = 0; m_len = 2; m_off = 0; m_w = 1;
      end else begin
         m_term = m_primed ? m_len : clampl(int'(frame_len));
         if (m_cnt == m_term - 1) begin
            m_cnt    = 0;
            m_primed = 1;
            m_len    = clampl(int'(frame_len));
            m_off    = int'(offset);
            m_w      = wdec(width_sel);
         end else begin
            m_cnt++;
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at cnt=%0d actual=%0b expected=%0b", tag, what, m_cnt, act, exp);
      end
   endtask

   // One cycle: wait to the falling edge, compare both outputs.
   task automatic cyc();
      logic exp_fs, exp_tk;
      string tf, tt;
      bit pend;
      @(negedge clk);
      exp_fs = m_primed && (m_cnt >= m_off) && (m_cnt < m_off + m_w);
      exp_tk = m_primed && (m_cnt == 0);
      pend   = (clampl(int'(frame_len)) != m_len) || (int'(offset) != m_off) ||
               (wdec(width_sel) != m_w);
      if (!rst_n || !m_primed)            tf = "R5";
      else if (m_off == 1023)             tf = "R4";
      else if (m_off >= m_len)            tf = "R4";
      else if (m_off + m_w > m_len)       tf = "R7";
      else if (pend)                      tf = "R6";
      else if (exp_fs && m_cnt == m_off)  tf = "R3";
      else if (exp_fs)                    tf = "R8";
      else                                tf = "R2";
      tt = (!rst_n || !m_primed) ? "R5" : "R1";
      chk(fsync, exp_fs, tf, "fsync");
      chk(frame_tick, exp_tk, tt, "frame_tick");
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic set_cfg(input int l, input int w, input int o);
      frame_len = 11'(l);
      width_sel = 2'(w);
      offset    = 10'(o);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (120000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5eed_0413));

      // Reset state (R5)
      set_cfg(20, 0, 0);
      run(4);
      rst_n = 1'b1;

      // R5: first frame quiet, then R1/R3 with offset 0 width 1
      run(60);

      // R2/R8: every width code, offset 5, frame 40
      for (int w = 0; w < 4; w++) begin
         set_cfg(40, w, 5);
         run(120);
      end

      // R7: truncation at frame end, then offset 0 next to it
      set_cfg(30, 3, 25);
      run(90);
      set_cfg(30, 3, 0);
      run(60);

      // R4: offset beyond frame length
      set_cfg(30, 1, 40);
      run(90);

      // R4: maximum offset, fitting, truncated, and beyond
      set_cfg(1100, 2, 1023);
      run(2300);
      set_cfg(1030, 3, 1023);
      run(2100);
      set_cfg(1000, 0, 1023);
      run(2100);

      // R1: lengths 0 and 1 act as 2
      set_cfg(0, 0, 0);
      run(1010);
      set_cfg(1, 1, 1);
      run(20);

      // R6: settings written in the last cycle of a frame apply to the next frame
      for (int k = 0; k < 6; k++) begin
         set_cfg(25 + 3 * k, k % 4, 2 + k);
         while (!(m_primed && m_cnt == m_len - 1)) cyc();
         set_cfg(18 + 5 * k, (k + 1) % 4, 16 - k);
         run(3);
         set_cfg(50, (k + 2) % 4, 1); // mid-frame change, must wait a frame
         run(120);
      end

      // Constrained random: occasional mid-frame setting changes (R6, R2, R3, R7)
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(19, 0) == 0)
            set_cfg($urandom_range(80, 2), $urandom_range(3, 0), $urandom_range(90, 0));
         cyc();
      end

      // R5: reset in mid-operation quiets the outputs again
      rst_n = 1'b0;
      run(3);
      rst_n = 1'b1;
      set_cfg(15, 1, 3);
      run(60);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule